// File: doc/BRIEF.md
# Age-Ordered Multi-Issue Instruction Queue

This block holds renamed instructions between dispatch and execution. A group of up to `DISP_W` instructions arrives each cycle in program order. Each carries an operation code, a destination tag, an age stamp and `NSRC` source operands, each with a tag and a ready flag. The queue keeps every waiting entry in a compacted array, with the oldest entry in slot 0 and new arrivals written at the tail. Result tags broadcast on the wakeup ports mark matching sources as ready.

Each cycle a picker takes the oldest entries whose sources are all ready, up to `ISSUE_W` of them. It presents them on the issue lanes, oldest on lane 0. At the next clock edge those entries leave the queue, and the survivors close up so that age order still runs from slot 0 upward. Dispatch is held back when the group does not fit. A flush, which carries an age threshold, discards every entry younger than a mispredicted instruction.

The defaults give a 20-entry queue that issues 4 per cycle. Setting `DEPTH=15, ISSUE_W=2` gives the smaller floating-point flavour.

Top module: `age_issue_queue`

## Requirements
- R1: After reset the queue is empty: all `iss_vld` lanes are 0, and `disp_stall` is 0 while `disp_vld` is 0.
- R2: An entry is eligible for issue only when every one of its source ready flags is 1 (1 means the operand is available). An entry with any flag at 0 is never issued.
- R3: In a cycle without flush, the queue issues min(`ISSUE_W`, number of eligible entries) entries, and these are the oldest eligible ones. Lane 0 carries the oldest, lanes are filled from 0 with no gaps, and each lane shows that entry's op, destination tag and age.
- R4: Issued entries are gone from the queue after the clock edge of their issue cycle. The remaining entries keep their relative age order, and new entries are placed behind all older ones.
- R5: A wakeup lane with `wb_vld` set and `wb_tag` equal to a waiting source tag sets that source ready at the clock edge. The entry can issue in the following cycle at the earliest, never in the broadcast cycle itself.
- R6: A wakeup whose tag matches a source of an instruction being accepted in the same cycle marks that source ready on entry.
- R7: Dispatch lanes must be valid from lane 0 upward with no gaps. A group is accepted only when its lane count is at most the number of free slots counted before this cycle's issue. Otherwise `disp_stall` is 1 and no lane of the group is written.
- R8: With `flush_vld` set, every entry whose age `a` satisfies (a − `flush_age`) mod 2^`AGE_W` being non-zero with its top bit clear is removed. Entries with the same or an older age stay. In a flush cycle nothing issues and no dispatch group is accepted, so `disp_stall` is 1 if any dispatch lane is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_vld | input | DISP_W | Valid per dispatch lane, packed from lane 0 |
| disp_op | input | DISP_W*OP_W | Operation code, lane k at bits [k*OP_W +: OP_W] |
| disp_src_tag | input | DISP_W*NSRC*TAG_W | Source tags, lane k source s at [(k*NSRC+s)*TAG_W +: TAG_W] |
| disp_src_rdy | input | DISP_W*NSRC | Source ready flags, lane k source s at bit k*NSRC+s |
| disp_dst | input | DISP_W*TAG_W | Destination tag per lane |
| disp_age | input | DISP_W*AGE_W | Age stamp per lane, increasing in program order |
| disp_stall | output | 1 | The offered group was not accepted this cycle |
| wb_vld | input | WB_W | Valid per wakeup lane |
| wb_tag | input | WB_W*TAG_W | Broadcast result tag per wakeup lane |
| flush_vld | input | 1 | Remove entries younger than `flush_age` |
| flush_age | input | AGE_W | Age of the mispredicted instruction |
| iss_vld | output | ISSUE_W | Valid per issue lane, packed from lane 0 |
| iss_op | output | ISSUE_W*OP_W | Operation code of each issued entry |
| iss_dst | output | ISSUE_W*TAG_W | Destination tag of each issued entry |
| iss_age | output | ISSUE_W*AGE_W | Age stamp of each issued entry |

## Verification
On every cycle the assertions check several properties of the array. The occupied slots form one unbroken run from slot 0, and ages rise from slot to slot. The issue count equals the lesser of the issue width and the number of eligible entries. The issue lanes are packed. A flush cycle issues nothing, and a cycle without flush or dispatch shrinks the queue by exactly the number issued. Some behaviour can only be shown by the bench, because it compares against its own ordered reference list. This covers which entries are picked and with what payload, the one-cycle gap between a wakeup and its issue, same-cycle wakeup of a dispatching instruction, whole-group rejection at the full boundary, and which entries survive a flush.

// File: rtl/iq_pkg.sv
package iq_pkg;

   localparam int unsigned IQ_MAX_AGE_W = 32;

   // True when stamp a lies strictly after stamp b on a circular w-bit scale.
   function automatic logic age_after(input logic [31:0] a,
                                      input logic [31:0] b,
                                      input int unsigned w);
      logic [31:0] msk;
      logic [31:0] half;
      logic [31:0] d;
      msk  = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
      half = 32'd1 << (w - 1);
      d    = (a - b) & msk;
      return (d != 32'd0) && ((d & half) == 32'd0);
   endfunction

endpackage

// File: rtl/iq_wakeup.sv
module iq_wakeup #(
   parameter int unsigned NSRC  = 2,
   parameter int unsigned TAG_W = 7,
   parameter int unsigned WB_W  = 4
) (
   input  logic [NSRC*(TAG_W+1)-1:0] src_in,
   input  logic [WB_W-1:0]           wb_vld,
   input  logic [WB_W*TAG_W-1:0]     wb_tag,
   output logic [NSRC*(TAG_W+1)-1:0] src_out
);
   localparam int unsigned S1 = TAG_W + 1;

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      logic [TAG_W-1:0] tag;
      logic [WB_W-1:0]  hit;
      assign tag = src_in[s*S1+1 +: TAG_W];
      for (genvar w = 0; w < WB_W; w++) begin : g_port
         assign hit[w] = wb_vld[w] && (wb_tag[w*TAG_W +: TAG_W] == tag);
      end
      assign src_out[s*S1 +: S1] = {tag, src_in[s*S1] | (|hit)};
   end

endmodule

// File: rtl/iq_select.sv
module iq_select #(
   parameter int unsigned DEPTH   = 20,
   parameter int unsigned ISSUE_W = 4,
   localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned SW     = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1
) (
   input  logic [DEPTH-1:0]   req,
   output logic [DEPTH-1:0]   gnt,
   output logic [ISSUE_W-1:0] sel_vld,
   output logic [IDX_W-1:0]   sel_idx [ISSUE_W]
);
   // Scan from the oldest slot upward; the first ISSUE_W requests win.
   always_comb begin
      int unsigned cnt;
      cnt     = 0;
      gnt     = '0;
      sel_vld = '0;
      for (int k = 0; k < ISSUE_W; k++) sel_idx[k] = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (req[i] && (cnt < ISSUE_W)) begin
            gnt[i]               = 1'b1;
            sel_vld[SW'(cnt)]    = 1'b1;
            sel_idx[SW'(cnt)]    = IDX_W'(i);
            cnt                  = cnt + 1;
         end
      end
   end

endmodule

// File: rtl/iq_compact.sv
module iq_compact #(
   parameter int unsigned DEPTH  = 20,
   parameter int unsigned DISP_W = 4,
   parameter int unsigned PAY_W  = 23,
   parameter int unsigned SRC_W  = 16,
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned DCW   = $clog2(DISP_W + 1)
) (
   input  logic [DEPTH-1:0] keep,
   input  logic [PAY_W-1:0] old_pay [DEPTH],
   input  logic [SRC_W-1:0] old_src [DEPTH],
   input  logic             insert,
   input  logic [DCW-1:0]   in_cnt,
   input  logic [PAY_W-1:0] new_pay [DISP_W],
   input  logic [SRC_W-1:0] new_src [DISP_W],
   output logic [DEPTH-1:0] nxt_vld,
   output logic [PAY_W-1:0] nxt_pay [DEPTH],
   output logic [SRC_W-1:0] nxt_src [DEPTH]
);
   // Survivors slide down in order, then the accepted group lands behind them.
   always_comb begin
      int unsigned pos;
      pos     = 0;
      nxt_vld = '0;
      for (int j = 0; j < DEPTH; j++) begin
         nxt_pay[j] = '0;
         nxt_src[j] = '0;
      end
      for (int i = 0; i < DEPTH; i++) begin
         if (keep[i]) begin
            nxt_vld[IDX_W'(pos)] = 1'b1;
            nxt_pay[IDX_W'(pos)] = old_pay[i];
            nxt_src[IDX_W'(pos)] = old_src[i];
            pos = pos + 1;
         end
      end
      for (int k = 0; k < DISP_W; k++) begin
         if (insert && (k < int'(in_cnt)) && ((pos + k) < DEPTH)) begin
            nxt_vld[IDX_W'(pos + k)] = 1'b1;
            nxt_pay[IDX_W'(pos + k)] = new_pay[k];
            nxt_src[IDX_W'(pos + k)] = new_src[k];
         end
      end
   end

endmodule

// File: rtl/age_issue_queue.sv
module age_issue_queue #(
   parameter int unsigned DEPTH   = 20,
   parameter int unsigned ISSUE_W = 4,
   parameter int unsigned DISP_W  = 4,
   parameter int unsigned NSRC    = 2,
   parameter int unsigned WB_W    = 4,
   parameter int unsigned TAG_W   = 7,
   parameter int unsigned OP_W    = 8,
   parameter int unsigned AGE_W   = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [DISP_W-1:0]           disp_vld,
   input  logic [DISP_W*OP_W-1:0]      disp_op,
   input  logic [DISP_W*NSRC*TAG_W-1:0] disp_src_tag,
   input  logic [DISP_W*NSRC-1:0]      disp_src_rdy,
   input  logic [DISP_W*TAG_W-1:0]     disp_dst,
   input  logic [DISP_W*AGE_W-1:0]     disp_age,
   output logic                        disp_stall,
   input  logic [WB_W-1:0]             wb_vld,
   input  logic [WB_W*TAG_W-1:0]       wb_tag,
   input  logic                        flush_vld,
   input  logic [AGE_W-1:0]            flush_age,
   output logic [ISSUE_W-1:0]          iss_vld,
   output logic [ISSUE_W*OP_W-1:0]     iss_op,
   output logic [ISSUE_W*TAG_W-1:0]    iss_dst,
   output logic [ISSUE_W*AGE_W-1:0]    iss_age
);
   import iq_pkg::*;

   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam int unsigned DCW   = $clog2(DISP_W + 1);
   localparam int unsigned S1    = TAG_W + 1;
   localparam int unsigned SRC_W = NSRC * S1;
   localparam int unsigned PAY_W = OP_W + TAG_W + AGE_W;
   localparam int unsigned AGE_LO = 0;
   localparam int unsigned DST_LO = AGE_W;
   localparam int unsigned OP_LO  = AGE_W + TAG_W;

   // ---------------- elaboration-time parameter checks ----------------
   if (DEPTH < 2)                           begin : g_bad_depth  $error("DEPTH must be at least 2");            end
   if (ISSUE_W < 1 || ISSUE_W > DEPTH)      begin : g_bad_issue  $error("ISSUE_W must lie in 1..DEPTH");        end
   if (DISP_W < 1 || DISP_W > DEPTH)        begin : g_bad_disp   $error("DISP_W must lie in 1..DEPTH");         end
   if (NSRC < 1)                            begin : g_bad_nsrc   $error("NSRC must be at least 1");             end
   if (WB_W < 1)                            begin : g_bad_wb     $error("WB_W must be at least 1");             end
   if (TAG_W < 1 || OP_W < 1)               begin : g_bad_width  $error("TAG_W and OP_W must be non-zero");     end
   if (AGE_W < 2 || AGE_W > IQ_MAX_AGE_W)   begin : g_bad_age    $error("AGE_W must lie in 2..32");             end
   if ((1 << (AGE_W - 1)) <= DEPTH + DISP_W) begin : g_bad_span  $error("AGE_W too narrow for queue span");     end

   // ---------------- state ----------------
   logic [DEPTH-1:0] vld_q;
   logic [PAY_W-1:0] pay_q [DEPTH];
   logic [SRC_W-1:0] src_q [DEPTH];

   logic [DEPTH-1:0] nxt_vld;
   logic [PAY_W-1:0] nxt_pay [DEPTH];
   logic [SRC_W-1:0] nxt_src [DEPTH];

   // ---------------- per-slot readiness, wakeup, flush kill ----------------
   logic [DEPTH-1:0]       ent_rdy;
   logic [DEPTH-1:0]       kill;
   logic [SRC_W-1:0]       src_woke [DEPTH];
   logic [DEPTH*AGE_W-1:0] age_flat;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [NSRC-1:0] rbits;
      for (genvar s = 0; s < NSRC; s++) begin : g_rb
         assign rbits[s] = src_q[i][s*S1];
      end
      assign ent_rdy[i] = vld_q[i] & (&rbits);
      assign age_flat[i*AGE_W +: AGE_W] = pay_q[i][AGE_LO +: AGE_W];
      assign kill[i] = flush_vld &&
                       age_after(32'(pay_q[i][AGE_LO +: AGE_W]), 32'(flush_age), AGE_W);

      iq_wakeup #(.NSRC(NSRC), .TAG_W(TAG_W), .WB_W(WB_W)) u_wake (
         .src_in (src_q[i]),
         .wb_vld (wb_vld),
         .wb_tag (wb_tag),
         .src_out(src_woke[i])
      );
   end

   // ---------------- oldest-ready selection ----------------
   logic [DEPTH-1:0]   req;
   logic [DEPTH-1:0]   gnt;
   logic [ISSUE_W-1:0] sel_vld;
   logic [IDX_W-1:0]   sel_idx [ISSUE_W];

   assign req = flush_vld ? '0 : ent_rdy;

   iq_select #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) u_sel (
      .req    (req),
      .gnt    (gnt),
      .sel_vld(sel_vld),
      .sel_idx(sel_idx)
   );

   assign iss_vld = sel_vld;
   for (genvar k = 0; k < ISSUE_W; k++) begin : g_iss
      logic [PAY_W-1:0] p;
      assign p = sel_vld[k] ? pay_q[sel_idx[k]] : '0;
      assign iss_op [k*OP_W  +: OP_W ] = p[OP_LO  +: OP_W ];
      assign iss_dst[k*TAG_W +: TAG_W] = p[DST_LO +: TAG_W];
      assign iss_age[k*AGE_W +: AGE_W] = p[AGE_LO +: AGE_W];
   end

   // ---------------- dispatch acceptance ----------------
   logic [CNT_W-1:0] occ;
   logic [CNT_W-1:0] free_slots;
   logic [DCW-1:0]   in_cnt;
   logic             accept;

   assign occ        = CNT_W'($countones(vld_q));
   assign free_slots = CNT_W'(DEPTH) - occ;
   assign in_cnt     = DCW'($countones(disp_vld));
   assign accept     = !flush_vld && (CNT_W'(in_cnt) <= free_slots);
   assign disp_stall = (in_cnt != '0) && !accept;

   logic [PAY_W-1:0] new_pay [DISP_W];
   logic [SRC_W-1:0] new_src [DISP_W];

   for (genvar k = 0; k < DISP_W; k++) begin : g_lane
      logic [SRC_W-1:0] raw;
      for (genvar s = 0; s < NSRC; s++) begin : g_rs
         assign raw[s*S1 +: S1] = {disp_src_tag[(k*NSRC+s)*TAG_W +: TAG_W], disp_src_rdy[k*NSRC+s]};
      end
      assign new_pay[k] = {disp_op[k*OP_W +: OP_W], disp_dst[k*TAG_W +: TAG_W],
                           disp_age[k*AGE_W +: AGE_W]};

      iq_wakeup #(.NSRC(NSRC), .TAG_W(TAG_W), .WB_W(WB_W)) u_wake_in (
         .src_in (raw),
         .wb_vld (wb_vld),
         .wb_tag (wb_tag),
         .src_out(new_src[k])
      );
   end

   // ---------------- compaction ----------------
   iq_compact #(.DEPTH(DEPTH), .DISP_W(DISP_W), .PAY_W(PAY_W), .SRC_W(SRC_W)) u_cmp (
      .keep   (vld_q & ~gnt & ~kill),
      .old_pay(pay_q),
      .old_src(src_woke),
      .insert (accept),
      .in_cnt (in_cnt),
      .new_pay(new_pay),
      .new_src(new_src),
      .nxt_vld(nxt_vld),
      .nxt_pay(nxt_pay),
      .nxt_src(nxt_src)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         pay_q <= '{default: '0};
         src_q <= '{default: '0};
      end else begin
         vld_q <= nxt_vld;
         pay_q <= nxt_pay;
         src_q <= nxt_src;
      end
   end

endmodule

// File: rtl/age_issue_queue_chk.sv
module age_issue_queue_chk #(
   parameter int unsigned DEPTH   = 20,
   parameter int unsigned ISSUE_W = 4,
   parameter int unsigned DISP_W  = 4,
   parameter int unsigned AGE_W   = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [DEPTH-1:0]       vld_q,
   input logic [DEPTH-1:0]       ent_rdy,
   input logic [ISSUE_W-1:0]     iss_vld,
   input logic                   flush_vld,
   input logic [DISP_W-1:0]      disp_vld,
   input logic                   disp_stall,
   input logic [DEPTH*AGE_W-1:0] age_flat
);
   int unsigned occ;
   int unsigned n_iss;
   int unsigned n_rdy;
   int unsigned exp_iss;

   always_comb begin
      occ     = $countones(vld_q);
      n_iss   = $countones(iss_vld);
      n_rdy   = $countones(ent_rdy);
      exp_iss = (n_rdy < ISSUE_W) ? n_rdy : ISSUE_W;
   end

   // R4
   slot_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q & (vld_q + 1'b1)) == '0);

   // R3
   issue_lanes_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_vld & (iss_vld + 1'b1)) == '0);

   // R3
   issue_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flush_vld |-> (n_iss == exp_iss));

   // R8
   flush_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_vld |-> (iss_vld == '0));

   // R7
   stall_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_stall |=> (occ <= $past(occ)));

   // R4
   drain_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_vld && (disp_vld == '0)) |=> (occ == $past(occ) - $past(n_iss)));

   for (genvar i = 0; i < DEPTH - 1; i++) begin : g_ord
      // R4
      age_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
         vld_q[i+1] |-> iq_pkg::age_after(32'(age_flat[(i+1)*AGE_W +: AGE_W]),
                                          32'(age_flat[i*AGE_W +: AGE_W]), AGE_W));
   end

endmodule

bind age_issue_queue age_issue_queue_chk #(
   .DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .DISP_W(DISP_W), .AGE_W(AGE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .vld_q     (vld_q),
   .ent_rdy   (ent_rdy),
   .iss_vld   (iss_vld),
   .flush_vld (flush_vld),
   .disp_vld  (disp_vld),
   .disp_stall(disp_stall),
   .age_flat  (age_flat)
);

// File: tb/age_issue_queue_bench.sv
`timescale 1ns/1ps
module age_issue_queue_bench;
   localparam int DEPTH = 20, ISSUE_W = 4, DISP_W = 4, NSRC = 2, WB_W = 4;
   localparam int TAG_W = 7, OP_W = 8, AGE_W = 8;
   localparam logic [TAG_W-1:0] NEVER = 7'd127;

   logic clk = 1'b0;
   always #2 clk = ~clk;
   logic rst_n;

   logic [DISP_W-1:0]            disp_vld;
   logic [OP_W-1:0]              b_op  [DISP_W];
   logic [TAG_W-1:0]             b_dst [DISP_W];
   logic [AGE_W-1:0]             b_age [DISP_W];
   logic [TAG_W-1:0]             b_st  [DISP_W][NSRC];
   logic                         b_sr  [DISP_W][NSRC];
   logic [WB_W-1:0]              wb_vld;
   logic [TAG_W-1:0]             b_wt  [WB_W];
   logic                         flush_vld;
   logic [AGE_W-1:0]             flush_age;

   logic [DISP_W*OP_W-1:0]       disp_op;
   logic [DISP_W*NSRC*TAG_W-1:0] disp_src_tag;
   logic [DISP_W*NSRC-1:0]       disp_src_rdy;
   logic [DISP_W*TAG_W-1:0]      disp_dst;
   logic [DISP_W*AGE_W-1:0]      disp_age;
   logic [WB_W*TAG_W-1:0]        wb_tag;
   logic                         disp_stall;
   logic [ISSUE_W-1:0]           iss_vld;
   logic [ISSUE_W*OP_W-1:0]      iss_op;
   logic [ISSUE_W*TAG_W-1:0]     iss_dst;
   logic [ISSUE_W*AGE_W-1:0]     iss_age;

   always_comb begin
      for (int k = 0; k < DISP_W; k++) begin
         disp_op [k*OP_W  +: OP_W ] = b_op[k];
         disp_dst[k*TAG_W +: TAG_W] = b_dst[k];
         disp_age[k*AGE_W +: AGE_W] = b_age[k];
         for (int s = 0; s < NSRC; s++) begin
            disp_src_tag[(k*NSRC+s)*TAG_W +: TAG_W] = b_st[k][s];
            disp_src_rdy[k*NSRC+s]                  = b_sr[k][s];
         end
      end
      for (int w = 0; w < WB_W; w++) wb_tag[w*TAG_W +: TAG_W] = b_wt[w];
   end

   age_issue_queue #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .DISP_W(DISP_W), .NSRC(NSRC),
                     .WB_W(WB_W), .TAG_W(TAG_W), .OP_W(OP_W), .AGE_W(AGE_W)) u_age_issue_queue (
      .clk(clk), .rst_n(rst_n), .disp_vld(disp_vld), .disp_op(disp_op),
      .disp_src_tag(disp_src_tag), .disp_src_rdy(disp_src_rdy), .disp_dst(disp_dst),
      .disp_age(disp_age), .disp_stall(disp_stall), .wb_vld(wb_vld), .wb_tag(wb_tag),
      .flush_vld(flush_vld), .flush_age(flush_age), .iss_vld(iss_vld), .iss_op(iss_op),
      .iss_dst(iss_dst), .iss_age(iss_age));

   // ---------------- reference list, oldest first ----------------
   int               mcnt;
   logic [OP_W-1:0]  m_op  [DEPTH];
   logic [TAG_W-1:0] m_dst [DEPTH];
   logic [AGE_W-1:0] m_age [DEPTH];
   logic [TAG_W-1:0] m_tag [DEPTH][NSRC];
   logic             m_rdy [DEPTH][NSRC];

   int n_chk, n_fail, nlane, nwb;
   logic [AGE_W-1:0] seq;
   string cur_req;

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic younger(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
      logic [AGE_W-1:0] d;
      d = a - b;
      return (d != '0) && !d[AGE_W-1];
   endfunction

   function automatic logic woke(input logic [TAG_W-1:0] t);
      logic h;
      h = 1'b0;
      for (int w = 0; w < WB_W; w++) if (wb_vld[w] && b_wt[w] == t) h = 1'b1;
      return h;
   endfunction

   task automatic clear_in();
      nlane = 0; nwb = 0;
      disp_vld = '0; wb_vld = '0; flush_vld = 1'b0; flush_age = '0;
      for (int k = 0; k < DISP_W; k++) begin
         b_op[k] = '0; b_dst[k] = '0; b_age[k] = '0;
         for (int s = 0; s < NSRC; s++) begin b_st[k][s] = '0; b_sr[k][s] = 1'b0; end
      end
      for (int w = 0; w < WB_W; w++) b_wt[w] = '0;
   endtask

   task automatic push(input logic r0, input logic r1, input logic [TAG_W-1:0] t0, input logic [TAG_W-1:0] t1);
      disp_vld[nlane] = 1'b1;
      b_op[nlane]  = seq ^ 8'h5A;
      b_dst[nlane] = TAG_W'(seq * 3);
      b_age[nlane] = seq;
      b_st[nlane][0] = t0; b_sr[nlane][0] = r0;
      b_st[nlane][1] = t1; b_sr[nlane][1] = r1;
      seq = seq + 1'b1;
      nlane++;
   endtask

   task automatic wake(input logic [TAG_W-1:0] t);
      wb_vld[nwb] = 1'b1;
      b_wt[nwb]   = t;
      nwb++;
   endtask

   task automatic step();
      int sel [ISSUE_W];
      logic iss_m [DEPTH];
      int nsel, icnt, tc;
      logic acc;
      logic [OP_W-1:0]  t_op  [DEPTH];
      logic [TAG_W-1:0] t_dst [DEPTH];
      logic [AGE_W-1:0] t_age [DEPTH];
      logic [TAG_W-1:0] t_tag [DEPTH][NSRC];
      logic             t_rdy [DEPTH][NSRC];
      #1;
      nsel = 0;
      for (int i = 0; i < DEPTH; i++) iss_m[i] = 1'b0;
      for (int i = 0; i < mcnt; i++)
         if (!flush_vld && m_rdy[i][0] && m_rdy[i][1] && nsel < ISSUE_W) begin
            sel[nsel] = i; iss_m[i] = 1'b1; nsel++;
         end
      icnt = $countones(disp_vld);
      acc  = !flush_vld && (icnt <= DEPTH - mcnt);
      for (int k = 0; k < ISSUE_W; k++) begin
         chk(cur_req, "issue lane valid", 64'(iss_vld[k]), 64'(k < nsel));
         if (k < nsel) begin
            chk(cur_req, "issue op",  64'(iss_op [k*OP_W  +: OP_W ]), 64'(m_op [sel[k]]));
            chk(cur_req, "issue dst", 64'(iss_dst[k*TAG_W +: TAG_W]), 64'(m_dst[sel[k]]));
            chk(cur_req, "issue age", 64'(iss_age[k*AGE_W +: AGE_W]), 64'(m_age[sel[k]]));
         end
      end
      chk((icnt != 0 && !acc && !flush_vld) ? "R7" : cur_req, "disp_stall",
          64'(disp_stall), 64'(icnt != 0 && !acc));
      @(posedge clk);
      tc = 0;
      for (int i = 0; i < mcnt; i++) begin
         if (!iss_m[i] && !(flush_vld && younger(m_age[i], flush_age))) begin
            t_op[tc] = m_op[i]; t_dst[tc] = m_dst[i]; t_age[tc] = m_age[i];
            for (int s = 0; s < NSRC; s++) begin
               t_tag[tc][s] = m_tag[i][s];
               t_rdy[tc][s] = m_rdy[i][s] | woke(m_tag[i][s]);
            end
            tc++;
         end
      end
      if (acc)
         for (int k = 0; k < icnt; k++) begin
            t_op[tc] = b_op[k]; t_dst[tc] = b_dst[k]; t_age[tc] = b_age[k];
            for (int s = 0; s < NSRC; s++) begin
               t_tag[tc][s] = b_st[k][s];
               t_rdy[tc][s] = b_sr[k][s] | woke(b_st[k][s]);
            end
            tc++;
         end
      for (int i = 0; i < tc; i++) begin
         m_op[i] = t_op[i]; m_dst[i] = t_dst[i]; m_age[i] = t_age[i];
         for (int s = 0; s < NSRC; s++) begin m_tag[i][s] = t_tag[i][s]; m_rdy[i][s] = t_rdy[i][s]; end
      end
      mcnt = tc;
      @(negedge clk);
      clear_in();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      n_chk = 0; n_fail = 0; mcnt = 0; seq = '0;
      clear_in();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: empty after reset
      cur_req = "R1";
      #1;
      chk("R1", "iss_vld after reset", 64'(iss_vld), 64'd0);
      chk("R1", "disp_stall after reset", 64'(disp_stall), 64'd0);
      step();

      // R3: oldest ready first, mixed readiness
      cur_req = "R3";
      push(1, 0, 0, NEVER); push(1, 1, 0, 0); push(0, 1, NEVER, 0); push(1, 1, 0, 0);
      step();
      push(1, 1, 0, 0); push(1, 1, 0, 0); push(1, 1, 0, 0); push(1, 1, 0, 0);
      step();
      repeat (3) step();

      // R2: one source still pending blocks issue
      cur_req = "R2";
      push(1, 0, 0, 7'd40);
      wake(7'd41);
      step();
      repeat (2) step();
      wake(7'd40);
      step();
      step();

      // R5: wakeup takes effect one cycle later
      cur_req = "R5";
      push(0, 1, 7'd20, 0); push(1, 0, 0, 7'd21);
      step();
      wake(7'd21);
      step();
      step();
      wake(7'd20);
      step();
      step();

      // R6: wakeup in the dispatch cycle
      cur_req = "R6";
      push(0, 1, 7'd30, 0); push(1, 0, 0, 7'd31);
      wake(7'd30); wake(7'd31);
      step();
      step();
      // R4: drain stale entries left waiting on NEVER
      cur_req = "R4";
      wake(NEVER);
      step();
      repeat (3) step();

      // R7: back-pressure at the full boundary
      cur_req = "R7";
      for (int c = 0; c < 4; c++) begin
         for (int l = 0; l < 4; l++) push(0, 1, NEVER, 0);
         step();
      end
      push(0, 1, NEVER, 0); push(0, 1, NEVER, 0);
      step();
      for (int l = 0; l < 4; l++) push(0, 1, NEVER, 0);
      seq = seq - 8'd4;
      step();
      push(0, 1, NEVER, 0); push(0, 1, NEVER, 0);
      step();
      push(0, 1, NEVER, 0);
      seq = seq - 8'd1;
      step();
      chk("R7", "reference occupancy full", 64'(mcnt), 64'(DEPTH));

      // R8: flush keeps the ten oldest, blocks dispatch and issue
      cur_req = "R8";
      flush_vld = 1'b1; flush_age = m_age[9];
      wake(NEVER);
      push(1, 1, 0, 0);
      seq = seq - 8'd1;
      step();
      chk("R8", "entries left after flush", 64'(mcnt), 64'd10);
      cur_req = "R4";
      repeat (4) step();
      chk("R4", "queue drained", 64'(mcnt), 64'd0);

      // R3: sweep with random groups, wakeups and periodic flushes
      cur_req = "R3";
      for (int cyc = 0; cyc < 3000; cyc++) begin
         int n;
         n = $urandom_range(0, 4);
         for (int l = 0; l < n; l++)
            push(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 TAG_W'($urandom_range(0, 15)), TAG_W'($urandom_range(0, 15)));
         for (int w = 0; w < WB_W; w++)
            if ($urandom_range(0, 3) != 0) wake(TAG_W'($urandom_range(0, 15)));
         if ((cyc % 24) == 23 && mcnt > 0) begin
            flush_vld = 1'b1;
            flush_age = m_age[$urandom_range(0, (mcnt - 1) / 2)];
         end
         step();
      end
      for (int c = 0; c < 40 && mcnt > 0; c++) begin
         for (int w = 0; w < WB_W; w++) wake(TAG_W'((c * WB_W + w) % 16));
         step();
      end
      chk("R3", "queue empty after sweep", 64'(mcnt), 64'd0);

      summary();
      $finish;
   end

endmodule